// File: doc/BRIEF.md
# Phase-Accumulator Sine Synthesizer

This block produces a sampled sine wave whose frequency is set by an unsigned tuning word. A phase register adds the tuning word to itself on every clock and wraps at its width. The top bits of that phase index a 128-point table of signed samples, and the sample leaves through a clocked register.

The phase register is wider than the table index, and the low bits it drops are never used to look up a sample. Each step of the tuning word therefore moves the output frequency by f_clk / 2^10, which is finer than the table alone could give. The output frequency is M · f_clk / 1024 for a tuning word M. With a 50 MHz clock and M = 1, one period lasts 1024 clocks, which is about 48.8 kHz.

The raw phase is also brought out, so a neighbouring block can see where the waveform stands. The table is built in RTL from a 33-entry quarter wave, using the symmetry of the sine.

Top module: `sine_dds`

## Requirements
- R1: On each clock edge with reset low, `phase` becomes (`phase` + `tune`) mod 1024.
- R2: The table index is `phase[9:3]`. The three low phase bits never change the sample. After a reset with `tune` = 1, the first eight samples are 0 and the ninth is +6.
- R3: `sample` shows the table entry for the index held just before the previous clock edge, so the sample trails the phase by one clock.
- R4: Table entry k is floor(127·sin(2πk/128)) for k = 0..64. Entry k for k = 65..127 is the negative of entry k−64. This makes entry 0 = 0, entry 32 = +127, entry 64 = 0 and entry 96 = −127.
- R5: `sample` lies within −127..+127 and is never −128.
- R6: A synchronous, active-high `rst` sets `phase` and `sample` to 0 at the clock edge.
- R7: With `tune` = 0, `phase` and `sample` stay constant.
- R8: With `tune` = 512, successive samples are negatives of each other, because the two indices they come from lie 64 entries apart.
- R9: With a constant tuning word M, `phase` first returns to a given value after 1024 / gcd(M, 1024) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune | input | 10 | Unsigned tuning word, added to the phase each clock |
| sample | output | 8 | Two's-complement sine sample, registered |
| phase | output | 10 | Current phase accumulator value |

## Verification
The bench runs an independent model beside the design and compares the phase and the sample on every clock.

- **Dropped low bits.** A design that indexed the table with the low phase bits would give a nonzero sample long before the ninth clock after reset with a step of 1.
- **Half-scale tuning word.** With a step of 512, a table with broken symmetry or a wrong index slice would break the strict sign alternation between samples.
- **Zero tuning word.** A design that moved the phase with a step of 0 would change the output.
- **Period length.** Steps of 24 and 120 do not divide 1024, so a wrong wrap width would show up as a wrong period length.
- **Peaks and latency.** A missing read register would put the sample one clock early. A rounded rather than floored table would differ at entries such as 3 and 10.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Quarter-wave magnitude, index 0..32, floor(127*sin(2*pi*j/128))
  function automatic logic signed [7:0] quarter_mag(input logic [5:0] j);
    logic signed [7:0] m;
    case (j)
      6'd0:  m = 8'sd0;    6'd1:  m = 8'sd6;    6'd2:  m = 8'sd12;
      6'd3:  m = 8'sd18;   6'd4:  m = 8'sd24;   6'd5:  m = 8'sd30;
      6'd6:  m = 8'sd36;   6'd7:  m = 8'sd42;   6'd8:  m = 8'sd48;
      6'd9:  m = 8'sd54;   6'd10: m = 8'sd59;   6'd11: m = 8'sd65;
      6'd12: m = 8'sd70;   6'd13: m = 8'sd75;   6'd14: m = 8'sd80;
      6'd15: m = 8'sd85;   6'd16: m = 8'sd89;   6'd17: m = 8'sd94;
      6'd18: m = 8'sd98;   6'd19: m = 8'sd102;  6'd20: m = 8'sd105;
      6'd21: m = 8'sd108;  6'd22: m = 8'sd112;  6'd23: m = 8'sd114;
      6'd24: m = 8'sd117;  6'd25: m = 8'sd119;  6'd26: m = 8'sd121;
      6'd27: m = 8'sd123;  6'd28: m = 8'sd124;  6'd29: m = 8'sd125;
      6'd30: m = 8'sd126;  6'd31: m = 8'sd126;  6'd32: m = 8'sd127;
      default: m = 8'sd0;
    endcase
    return m;
  endfunction

  // Full-period entry for a 7-bit index, built from quarter-wave symmetry
  function automatic logic signed [7:0] sine_at(input logic [6:0] a);
    logic [5:0] j;
    logic signed [7:0] m;
    j = a[5] ? (6'd32 - {1'b0, a[4:0]}) : {1'b0, a[4:0]};
    m = quarter_mag(j);
    return a[6] ? -m : m;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] step,
  output logic [PW-1:0] acc
);
  // Wraps naturally modulo 2^PW
  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + step;
  end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
  import dds_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        addr,
  output logic signed [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic signed [DW-1:0] rom_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    localparam logic [6:0] IDX = 7'(g);
    assign rom_q[g] = DW'(sine_at(IDX));
  end

  // Registered read port, suitable for block memory
  always_ff @(posedge clk) begin
    if (rst) rd <= '0;
    else     rd <= rom_q[addr];
  end
endmodule

// File: rtl/sine_dds.sv
module sine_dds #(
  parameter int PW = 10,
  parameter int AW = 7,
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        tune,
  output logic signed [SW-1:0] sample,
  output logic [PW-1:0]        phase
);
  localparam int DROP = PW - AW;

  logic [AW-1:0] tbl_addr;

  dds_phase_acc #(.PW(PW)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .step (tune),
    .acc  (phase)
  );

  // Phase truncation: discard the DROP least significant bits
  assign tbl_addr = phase[PW-1:DROP];

  dds_sine_rom #(.AW(AW), .DW(SW)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (tbl_addr),
    .rd   (sample)
  );

  // Assertion support: set once a clocked reset has been seen
  logic past_ok = 1'b0;
  always_ff @(posedge clk) if (rst) past_ok <= 1'b1;

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst)) |-> (phase == PW'($past(phase) + $past(tune))));

  assert_peak_bound_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (sample != {1'b1, {(SW-1){1'b0}}}));

  assert_sync_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rst)) |-> (phase == '0 && sample == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && $past(tune) == '0) |-> $stable(phase));
endmodule

// File: tb/sine_dds_tb.sv
module sine_dds_tb;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [9:0]        tune = '0;
  logic signed [7:0] sample;
  logic [9:0]        phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sine_dds u_dut (.clk(clk), .rst(rst), .tune(tune), .sample(sample), .phase(phase));

  // Reference table from the requirement (R4)
  function automatic int ref_tab(int k);
    real r;
    int  j;
    j = (k > 64) ? k - 64 : k;
    r = 127.0 * $sin(2.0 * 3.141592653589793 * j / 128.0);
    return (k > 64) ? -int'($floor(r + 1.0e-9)) : int'($floor(r + 1.0e-9));
  endfunction

  // Independent cycle model
  int m_acc = 0;
  int m_smp = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0;
      m_smp = 0;
    end else begin
      m_smp = ref_tab(m_acc / 8);
      m_acc = (m_acc + int'(tune)) % 1024;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_model(input string tag);
    check({tag, " R1 phase"}, int'(phase), m_acc);
    check({tag, " R3 sample"}, int'(sample), m_smp);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_model(tag);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R6 phase clear", int'(phase), 0);
    check("R6 sample clear", int'(sample), 0);
    rst = 1'b0;
  endtask

  task automatic t_table;
    check("R4 entry0", ref_tab(0), 0);
    check("R4 entry32", ref_tab(32), 127);
    check("R4 entry64", ref_tab(64), 0);
    check("R4 entry96", ref_tab(96), -127);
    check("R4 entry3", ref_tab(3), 18);
    check("R4 entry10", ref_tab(10), 59);
  endtask

  task automatic t_low_bits;
    do_reset();
    tune = 10'd1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check("R2 low bits ignored", int'(sample), 0);
    end
    @(negedge clk);
    check("R2 first step", int'(sample), 6);
  endtask

  task automatic t_sweep;
    do_reset();
    tune = 10'd1;
    run(1100, "sweep step1");
    tune = 10'd37;
    run(300, "sweep step37");
    tune = 10'd1023;
    run(200, "sweep step1023");
  endtask

  task automatic t_peaks;
    bit hit_pos = 0;
    bit hit_neg = 0;
    do_reset();
    tune = 10'd8;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      cmp_model("peaks");
      if (sample == 8'sd127)  hit_pos = 1;
      if (sample == -8'sd127) hit_neg = 1;
      check("R5 never -128", int'(sample == -8'sd128), 0);
    end
    check("R4 positive peak seen", int'(hit_pos), 1);
    check("R4 negative peak seen", int'(hit_neg), 1);
  endtask

  task automatic t_hold;
    int p0;
    int s0;
    do_reset();
    tune = 10'd200;
    run(3, "hold lead");
    tune = 10'd0;
    @(negedge clk);
    cmp_model("hold");
    @(negedge clk);
    p0 = int'(phase);
    s0 = int'(sample);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R7 phase held", int'(phase), p0);
      check("R7 sample held", int'(sample), s0);
    end
  endtask

  task automatic t_half;
    int prev;
    do_reset();
    tune = 10'd136;
    run(2, "half lead");
    tune = 10'd512;
    run(2, "half settle");
    prev = int'(sample);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cmp_model("half");
      check("R8 alternating sign", int'(sample), -prev);
      prev = int'(sample);
    end
  endtask

  task automatic t_period(input int m, input int expect_len);
    int p0;
    int cnt;
    do_reset();
    tune = 10'(m);
    @(negedge clk);
    p0 = int'(phase);
    cnt = 0;
    do begin
      @(negedge clk);
      cmp_model("period");
      cnt++;
    end while (int'(phase) != p0 && cnt < 2000);
    check($sformatf("R9 period for step %0d", m), cnt, expect_len);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    t_table();
    do_reset();
    check("R6 reset phase", int'(phase), 0);
    t_low_bits();
    t_sweep();
    t_peaks();
    t_hold();
    t_half();
    t_period(1, 1024);
    t_period(8, 128);
    t_period(24, 128);
    t_period(120, 128);
    t_period(3, 1024);
    finish_run();
  end
endmodule